// File: doc/BRIEF.md
# Serial Bus Hold and Sleep Controller

This block watches the pins of a serial memory slave and decides when the slave's command engine may run and when its serial data output may be driven. It handles two suspend conditions. The first is a pause requested on the hold pin. The second is a low-power sleep state that a command puts the slave into and the next chip select takes it out of.

The chip select, serial clock and hold pins come from outside the system clock domain. A parameterised chain of flops brings each of them into that domain. All decisions are taken on the resynchronised copies.

The pause follows the hold pin only while the serial clock is low. A hold pin change made while the serial clock is high leaves the current state in place until the clock is seen low again.

The opcode decoder is not part of this block. It reports a fully received sleep opcode as a one-cycle pulse on `sleep_cmd_done`. Sleep then begins on the following rise of chip select. In sleep, every pin except chip select is ignored. A fall of chip select starts a recovery window of a fixed number of system clocks, during which `wake_busy` is high. The transfer that caused the wake-up is discarded until chip select rises again.

Top module: `sbus_suspend_ctrl`

## Requirements
- R1: After reset the block is awake and not paused: `eng_run`=1, `so_oe`=0 (chip select is high), `wake_busy`=0, `asleep`=0.
- R2: When the hold pin is seen low while the serial clock is seen low, the pause takes effect: `eng_run`=0 and `so_oe`=0, even with chip select low.
- R3: A hold pin change seen while the serial clock is high has no effect. The pause state changes only once the serial clock is seen low.
- R4: When the hold pin is seen high while the serial clock is seen low, the pause ends. With chip select low and the block awake, `eng_run` and `so_oe` return to 1.
- R5: A `sleep_cmd_done` pulse taken while chip select is low and the block is not paused, followed by a chip select rise, puts the block in sleep: `asleep`=1, `eng_run`=0, `so_oe`=0.
- R6: In sleep, serial clock and hold pin activity has no effect. `asleep` stays 1 and `wake_busy` stays 0.
- R7: A chip select fall while asleep clears `asleep` and raises `wake_busy` for exactly RECOV_CYC system clock cycles.
- R8: During recovery, and afterwards until chip select rises, `eng_run`=0 and `so_oe`=0. The transfer that began during sleep or recovery is discarded.
- R9: A chip select fall after recovery has ended starts a normal transfer: `eng_run`=1 and `so_oe`=1.
- R10: A chip select rise while paused does not enter sleep and discards a pending sleep request. A later chip select cycle without a new request leaves `asleep`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select pin, active low, asynchronous |
| sck | input | 1 | Serial clock pin, asynchronous |
| hold_n | input | 1 | Hold pin, active low, asynchronous |
| sleep_cmd_done | input | 1 | One-cycle pulse from the opcode decoder: sleep opcode fully received |
| eng_run | output | 1 | Enable for the command engine; 0 freezes it |
| so_oe | output | 1 | Output-enable gate for the serial data output |
| wake_busy | output | 1 | High during the wake-up recovery window |
| asleep | output | 1 | High while in the low-power state |

## Verification
The bench tries a hold pin change made while the serial clock is high. A design that reacted to it would pause or resume one clock phase early. The bench also counts the length of the recovery window cycle by cycle, which catches an off-by-one in the counter load or the exit test.

After recovery ends, the bench keeps chip select low. A design that forgot the stale transfer would re-enable the engine in the middle of a command it only partly saw.

Finally, the bench lets chip select rise while paused after a sleep request. A design that let that rise through would sleep, or would keep the request for a later cycle.

// File: rtl/sbus_susp_pkg.sv
package sbus_susp_pkg;
  typedef enum logic [1:0] {
    SL_AWAKE  = 2'd0,
    SL_ASLEEP = 2'd1,
    SL_WAKING = 2'd2
  } sleep_st_e;
endpackage

// File: rtl/sbus_in_sync.sv
module sbus_in_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[gi] <= RST_VAL;
        else        stg[gi] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[gi] <= RST_VAL;
        else        stg[gi] <= stg[gi-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sbus_hold_track.sv
module sbus_hold_track (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic hold_active
);
  logic hold_nx;
  logic hold_q;
  logic upd_en;

  // Pause state may only move while the serial clock is low.
  always_comb begin
    upd_en  = !sck_s;
    hold_nx = hold_q;
    if (upd_en) hold_nx = !hold_n_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_nx;
  end

  assign hold_active = hold_q;
endmodule

// File: rtl/sbus_sleep_fsm.sv
module sbus_sleep_fsm
  import sbus_susp_pkg::*;
#(
  parameter int unsigned RECOV_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic sleep_cmd_done,
  input  logic hold_active,
  output logic asleep,
  output logic wake_busy,
  output logic stale_xfer,
  output logic awake
);
  localparam int unsigned CW = $clog2(RECOV_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(RECOV_CYC - 1);

  sleep_st_e       st_q, st_nx;
  logic [CW-1:0]   cnt_q, cnt_nx;
  logic            pend_q, pend_nx;
  logic            stale_q, stale_nx;
  logic            cs_q;
  logic            cs_rise, cs_fall;

  assign cs_rise = cs_s & ~cs_q;
  assign cs_fall = ~cs_s & cs_q;

  always_comb begin
    st_nx    = st_q;
    cnt_nx   = cnt_q;
    pend_nx  = pend_q;
    stale_nx = stale_q;
    case (st_q)
      SL_AWAKE: begin
        if (sleep_cmd_done && !cs_s && !stale_q && !hold_active) pend_nx = 1'b1;
        if (cs_fall) pend_nx = 1'b0;
        if (cs_rise) begin
          pend_nx = 1'b0;
          if (pend_q && !hold_active) st_nx = SL_ASLEEP;
        end
      end
      SL_ASLEEP: begin
        if (cs_fall) begin
          st_nx  = SL_WAKING;
          cnt_nx = CNT_LOAD;
        end
      end
      SL_WAKING: begin
        if (cnt_q == '0) st_nx = SL_AWAKE;
        else             cnt_nx = cnt_q - 1'b1;
      end
      default: st_nx = SL_AWAKE;
    endcase
    if (cs_rise)                           stale_nx = 1'b0;
    else if (cs_fall && st_q != SL_AWAKE)  stale_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SL_AWAKE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      stale_q <= 1'b0;
      cs_q    <= 1'b1;
    end else begin
      st_q    <= st_nx;
      cnt_q   <= cnt_nx;
      pend_q  <= pend_nx;
      stale_q <= stale_nx;
      cs_q    <= cs_s;
    end
  end

  assign asleep     = (st_q == SL_ASLEEP);
  assign wake_busy  = (st_q == SL_WAKING);
  assign awake      = (st_q == SL_AWAKE);
  assign stale_xfer = stale_q;
endmodule

// File: rtl/sbus_suspend_ctrl.sv
module sbus_suspend_ctrl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RECOV_CYC   = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  input  logic sleep_cmd_done,
  output logic eng_run,
  output logic so_oe,
  output logic wake_busy,
  output logic asleep
);
  localparam int unsigned PIN_W = 3;
  localparam logic [PIN_W-1:0] PIN_IDLE = 3'b101; // cs_n high, sck low, hold_n high

  logic [1:0]       rst_sh;
  logic             rst_sync_n;
  logic [PIN_W-1:0] pins_s;
  logic             cs_s, sck_s, hold_n_s;
  logic             hold_active;
  logic             stale_xfer;
  logic             awake;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_sync_n = rst_sh[1];

  sbus_in_sync #(
    .WIDTH   (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({cs_n, sck, hold_n}),
    .q     (pins_s)
  );

  assign cs_s     = pins_s[2];
  assign sck_s    = pins_s[1];
  assign hold_n_s = pins_s[0];

  sbus_hold_track u_hold (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sck_s       (sck_s),
    .hold_n_s    (hold_n_s),
    .hold_active (hold_active)
  );

  sbus_sleep_fsm #(
    .RECOV_CYC (RECOV_CYC)
  ) u_sleep (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .cs_s           (cs_s),
    .sleep_cmd_done (sleep_cmd_done),
    .hold_active    (hold_active),
    .asleep         (asleep),
    .wake_busy      (wake_busy),
    .stale_xfer     (stale_xfer),
    .awake          (awake)
  );

  assign eng_run = awake & ~hold_active & ~stale_xfer;
  assign so_oe   = eng_run & ~cs_s;
endmodule

// File: rtl/sbus_suspend_ctrl_chk.sv
module sbus_suspend_ctrl_chk #(
  parameter int unsigned RECOV_CYC = 50000
) (
  input logic clk,
  input logic rst_n,
  input logic hold_active,
  input logic sck_s,
  input logic eng_run,
  input logic so_oe,
  input logic wake_busy,
  input logic asleep
);
  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_len <= 0;
    else if (wake_busy) busy_len <= busy_len + 1;
    else                busy_len <= 0;
  end

  // R2
  hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> (!eng_run && !so_oe));

  // R3
  hold_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active != $past(hold_active)) |-> !$past(sck_s));

  // R5
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (!so_oe && !eng_run && !wake_busy));

  // R7
  wake_from_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_busy) |-> $past(asleep));

  // R7
  wake_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_busy) |-> (busy_len == RECOV_CYC));

  // R8
  wake_exit_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_busy) |-> (!eng_run && !so_oe));
endmodule

bind sbus_suspend_ctrl sbus_suspend_ctrl_chk #(.RECOV_CYC(RECOV_CYC)) chk_i (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .hold_active (hold_active),
  .sck_s       (sck_s),
  .eng_run     (eng_run),
  .so_oe       (so_oe),
  .wake_busy   (wake_busy),
  .asleep      (asleep)
);

// File: tb/sbus_suspend_ctrl_tb_top.sv
module sbus_suspend_ctrl_tb_top;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned RECOV_CYC   = 16;
  localparam int unsigned SETTLE      = 6;

  typedef struct {
    string      tag;
    logic [3:0] exp; // {eng_run, so_oe, wake_busy, asleep}
  } exp_item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, sck, hold_n, sleep_cmd_done;
  logic eng_run, so_oe, wake_busy, asleep;

  int n_chk  = 0;
  int n_fail = 0;
  int busy_cnt  = 0;
  int busy_last = 0;
  int cyc = 0;
  exp_item_t exp_q[$];

  always #4 clk = ~clk;

  sbus_suspend_ctrl #(
    .SYNC_STAGES (SYNC_STAGES),
    .RECOV_CYC   (RECOV_CYC)
  ) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cs_n           (cs_n),
    .sck            (sck),
    .hold_n         (hold_n),
    .sleep_cmd_done (sleep_cmd_done),
    .eng_run        (eng_run),
    .so_oe          (so_oe),
    .wake_busy      (wake_busy),
    .asleep         (asleep)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Monitor: compares the queued expectations against the outputs.
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_item_t it;
      logic [3:0] act;
      it  = exp_q.pop_front();
      act = {eng_run, so_oe, wake_busy, asleep};
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: {eng_run,so_oe,wake_busy,asleep} actual=%b expected=%b",
                 it.tag, act, it.exp);
      end
    end
  end

  // Measures the length of each recovery window.
  always @(negedge clk) begin
    if (wake_busy) busy_cnt++;
    else if (busy_cnt != 0) begin
      busy_last = busy_cnt;
      busy_cnt  = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_outs(input string tag, input logic [3:0] e);
    exp_item_t it;
    @(posedge clk);
    it.tag = tag;
    it.exp = e;
    exp_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic check_val(input string tag, input int act, input int e);
    n_chk++;
    if (act != e) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, e);
    end
  endtask

  task automatic pulse_sleep();
    @(negedge clk);
    sleep_cmd_done = 1'b1;
    @(negedge clk);
    sleep_cmd_done = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; hold_n = 1'b1; sleep_cmd_done = 1'b0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(SETTLE);
    expect_outs("R1 reset", 4'b1000);

    cs_n = 1'b0; wait_cyc(SETTLE);
    expect_outs("R9 selected awake", 4'b1100);

    // Pause with the serial clock low.
    hold_n = 1'b0; wait_cyc(SETTLE);
    expect_outs("R2 hold with sck low", 4'b0000);

    // Release attempted with the serial clock high: ignored.
    sck = 1'b1; wait_cyc(2);
    hold_n = 1'b1; wait_cyc(SETTLE);
    expect_outs("R3 release while sck high ignored", 4'b0000);
    sck = 1'b0; wait_cyc(SETTLE);
    expect_outs("R4 release applied once sck low", 4'b1100);

    // Pause attempted with the serial clock high: ignored.
    sck = 1'b1; wait_cyc(2);
    hold_n = 1'b0; wait_cyc(SETTLE);
    expect_outs("R3 hold while sck high ignored", 4'b1100);
    sck = 1'b0; wait_cyc(SETTLE);
    expect_outs("R2 hold applied once sck low", 4'b0000);
    hold_n = 1'b1; wait_cyc(SETTLE);
    expect_outs("R4 resume", 4'b1100);

    // Sleep entry.
    pulse_sleep(); wait_cyc(SETTLE);
    expect_outs("R5 no sleep before cs rise", 4'b1100);
    cs_n = 1'b1; wait_cyc(SETTLE);
    expect_outs("R5 asleep after cs rise", 4'b0001);

    // Activity while asleep.
    for (int k = 0; k < 4; k++) begin
      sck = 1'b1; wait_cyc(2);
      hold_n = ~hold_n; wait_cyc(2);
      sck = 1'b0; wait_cyc(2);
    end
    hold_n = 1'b1; wait_cyc(SETTLE);
    expect_outs("R6 sck and hold ignored in sleep", 4'b0001);

    // Wake-up.
    cs_n = 1'b0; wait_cyc(SETTLE);
    expect_outs("R7 recovery in progress", 4'b0010);
    wait_cyc(RECOV_CYC + 4);
    check_val("R7 recovery length", busy_last, RECOV_CYC);
    expect_outs("R8 stale transfer stays blocked", 4'b0000);
    cs_n = 1'b1; wait_cyc(SETTLE);
    expect_outs("R8 idle after stale transfer", 4'b1000);
    cs_n = 1'b0; wait_cyc(SETTLE);
    expect_outs("R9 fresh transfer after recovery", 4'b1100);

    // Chip select rise while paused cancels the request.
    pulse_sleep(); wait_cyc(2);
    hold_n = 1'b0; wait_cyc(SETTLE);
    cs_n = 1'b1; wait_cyc(SETTLE);
    expect_outs("R10 no sleep on rise while held", 4'b0000);
    hold_n = 1'b1; wait_cyc(SETTLE);
    cs_n = 1'b0; wait_cyc(SETTLE);
    cs_n = 1'b1; wait_cyc(SETTLE);
    expect_outs("R10 request discarded", 4'b1000);

    wait_cyc(2);
    finish_run();
  end
endmodule